// File: doc/BRIEF.md
# Delay Tap Eye Window Calibrator

This block picks the capture delay for a source-synchronous ADC bus. After a start pulse it walks an input-delay line through all of its settings in rising order. For every setting it loads the tap into the delay element with a one-cycle strobe. It then runs a pattern checker twice, once on the I lane and once on the Q lane. Each run restarts the checker, leaves it running for a fixed dwell, and then reads the checker's lock flag and error count.

A setting passes when both lanes score zero. Passing settings in a row form a window. The sweep stops at the first failing setting that follows a window whose span (last minus first) has reached the minimum. A narrower window is thrown away and the sweep goes on. If a sweep finds no usable window, the whole sweep runs again after a long pause. When the search ends, the block loads the midpoint of the window through the same strobe and raises done. It also reports the tap, the span and two failure flags, and all of these hold until the next start.

The outer logic sets the ADC test pattern for each lane while the block runs. It does this from the lane-select output, which is low for I and high for Q.

Top module: `tap_eye_cal`

## Requirements
- R1: One calibration sweeps taps 0 to NUM_TAPS-1 in rising order. Each tap is put on `dly_tap` with a single-cycle `dly_load` pulse, so a sweep that examines k taps makes k load pulses before any final load.
- R2: For each tap, `chk_en` is low for one cycle and then high for DWELL cycles, first with `chk_q`=0 (I lane) and then with `chk_q`=1 (Q lane). This gives two enable rises per examined tap. `chk_en` is never high while `dly_load` is high.
- R3: A lane's score is its error count when its lock input is 1, and PENALTY (100) when its lock input is 0, whatever its error count. A tap passes only if the I score plus the Q score is zero.
- R4: A passing tap opens a window or extends the open one. A failing tap ends the sweep if the open window's span is at least MIN_SPAN (4). Otherwise it discards the window and the sweep continues.
- R5: A window that is still open when the last tap is examined is judged at that point. It succeeds if its span is at least MIN_SPAN.
- R6: If a sweep ends without success and fewer than ATTEMPTS (2) sweeps have run, the block waits PAUSE cycles and then sweeps again from tap 0.
- R7: On success the block drives `dly_tap` = (start+stop)/2, rounded down, and pulses `dly_load` once more. It then raises `done` with `best_tap` equal to that tap and `win_span` equal to stop minus start.
- R8: If no window is open when the last sweep ends, `err_noconv` is set. If a window is open but narrower than MIN_SPAN, `err_narrow` is set and `win_span` gives its span. In both cases `best_tap` is 0 and no final load is made.
- R9: `done` rises exactly 1 + k·(2·DWELL+4) cycles after the start edge for a single sweep of k taps. A second sweep adds PAUSE cycles plus its own taps. Start is ignored while `busy` is high, and all results stay stable while idle until the next start.
- R10: After reset `busy`, `done`, `dly_load` and `chk_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin a calibration |
| chk_i_lock | input | 1 | I-lane checker locked |
| chk_i_errs | input | ERR_W | I-lane checker error count |
| chk_q_lock | input | 1 | Q-lane checker locked |
| chk_q_errs | input | ERR_W | Q-lane checker error count |
| dly_tap | output | TAP_W | Tap value for the delay element |
| dly_load | output | 1 | Load strobe for the delay element |
| chk_en | output | 1 | Checker enable; a low-to-high edge restarts it |
| chk_q | output | 1 | Lane under test: 0 is I, 1 is Q |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Result valid |
| best_tap | output | TAP_W | Chosen tap, 0 on failure |
| win_span | output | TAP_W | Window span (stop minus start) |
| err_noconv | output | 1 | No window was open at the end |
| err_narrow | output | 1 | Window narrower than MIN_SPAN |

## Verification
Every examined tap costs exactly 2·DWELL+4 cycles, a retry adds PAUSE, and done appears one cycle after the final evaluation. So the bench's model counts from the checker masks the exact cycle on which done must rise after the start edge. The monitor compares that count against the cycles it measured at falling edges. The same model predicts the number of load pulses and enable rises for a run, and the monitor counts both between start and done. After each result the driver idles for several cycles and then checks that the outputs have not moved.

// File: rtl/tap_eye_cal.sv
module tap_eye_cal #(
  parameter int NUM_TAPS = 32,
  parameter int ERR_W    = 16,
  parameter int DWELL    = 2_000_000,
  parameter int PAUSE    = 400_000_000,
  parameter int MIN_SPAN = 4,
  parameter int ATTEMPTS = 2,
  parameter int PENALTY  = 100,
  localparam int TAP_W   = $clog2(NUM_TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             chk_i_lock,
  input  logic [ERR_W-1:0] chk_i_errs,
  input  logic             chk_q_lock,
  input  logic [ERR_W-1:0] chk_q_errs,
  output logic [TAP_W-1:0] dly_tap,
  output logic             dly_load,
  output logic             chk_en,
  output logic             chk_q,
  output logic             busy,
  output logic             done,
  output logic [TAP_W-1:0] best_tap,
  output logic [TAP_W-1:0] win_span,
  output logic             err_noconv,
  output logic             err_narrow
);
  localparam int CNT_MAX = (DWELL > PAUSE) ? DWELL : PAUSE;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int SC_W    = ERR_W + 2;
  localparam int ATT_W   = $clog2(ATTEMPTS + 1);
  localparam logic [TAP_W-1:0] LAST_T   = TAP_W'(NUM_TAPS - 1);
  localparam logic [TAP_W-1:0] MIN_T    = TAP_W'(MIN_SPAN);
  localparam logic [CNT_W-1:0] DWELL_T  = CNT_W'(DWELL - 1);
  localparam logic [CNT_W-1:0] PAUSE_T  = CNT_W'(PAUSE - 1);
  localparam logic [ATT_W-1:0] LAST_ATT = ATT_W'(ATTEMPTS - 1);
  localparam logic [SC_W-1:0]  PEN_S    = SC_W'(PENALTY);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_CLR, S_DWELL, S_EVAL, S_PAUSE, S_WRAP} st_t;

  st_t              st;
  logic             chan;
  logic [CNT_W-1:0] cnt;
  logic [SC_W-1:0]  score;
  logic             have;
  logic [TAP_W-1:0] ws, we;
  logic [ATT_W-1:0] att;

  logic             lk;
  logic [ERR_W-1:0] ec;
  logic [SC_W-1:0]  pts;
  logic             pass, wide_cur, stop_now, have_n, ok_n, ok;
  logic [TAP_W-1:0] ws_n, we_n, mid_n;
  logic [TAP_W:0]   sum_n;

  assign lk       = chan ? chk_q_lock : chk_i_lock;
  assign ec       = chan ? chk_q_errs : chk_i_errs;
  assign pts      = lk ? SC_W'(ec) : PEN_S;
  assign pass     = (score == '0);
  assign wide_cur = (we - ws) >= MIN_T;
  assign stop_now = !pass && have && wide_cur;
  assign have_n   = pass || (have && wide_cur);
  assign ws_n     = (pass && !have) ? dly_tap : ws;
  assign we_n     = pass ? dly_tap : we;
  assign ok_n     = have_n && ((we_n - ws_n) >= MIN_T);
  assign sum_n    = {1'b0, ws_n} + {1'b0, we_n};
  assign mid_n    = sum_n[TAP_W:1];
  assign ok       = have && wide_cur;

  assign dly_load = (st == S_LOAD) || (st == S_WRAP && ok);
  assign chk_en   = (st == S_DWELL);
  assign chk_q    = chan;
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; chan <= 1'b0; cnt <= '0; score <= '0;
      have <= 1'b0; ws <= '0; we <= '0; att <= '0; dly_tap <= '0;
      done <= 1'b0; best_tap <= '0; win_span <= '0;
      err_noconv <= 1'b0; err_narrow <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          dly_tap <= '0; att <= '0; have <= 1'b0;
          done <= 1'b0; err_noconv <= 1'b0; err_narrow <= 1'b0;
          st <= S_LOAD;
        end
        S_LOAD: begin
          chan <= 1'b0; score <= '0; st <= S_CLR;
        end
        S_CLR: begin
          cnt <= '0; st <= S_DWELL;
        end
        S_DWELL: begin
          if (cnt == DWELL_T) begin
            score <= score + pts;
            if (!chan) begin chan <= 1'b1; st <= S_CLR; end
            else st <= S_EVAL;
          end else cnt <= cnt + 1'b1;
        end
        S_EVAL: begin
          have <= have_n; ws <= ws_n; we <= we_n;
          if (stop_now || (dly_tap == LAST_T && (ok_n || att == LAST_ATT))) begin
            if (ok_n) dly_tap <= mid_n;
            st <= S_WRAP;
          end else if (dly_tap == LAST_T) begin
            att <= att + 1'b1; have <= 1'b0; cnt <= '0; st <= S_PAUSE;
          end else begin
            dly_tap <= dly_tap + 1'b1; st <= S_LOAD;
          end
        end
        S_PAUSE: begin
          if (cnt == PAUSE_T) begin dly_tap <= '0; st <= S_LOAD; end
          else cnt <= cnt + 1'b1;
        end
        S_WRAP: begin
          done       <= 1'b1;
          best_tap   <= ok ? dly_tap : '0;
          win_span   <= have ? (we - ws) : '0;
          err_noconv <= !have;
          err_narrow <= have && !wide_cur;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_tap_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && $past(st) == S_EVAL) |-> dly_tap == $past(dly_tap) + 1'b1);
  p_load_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dly_load |-> !chk_en);
  p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dly_load |=> !dly_load);
  p_one_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(err_noconv && err_narrow));
  p_good_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err_noconv && !err_narrow) |-> win_span >= MIN_T);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(done) && $stable(best_tap) && $stable(win_span)
                           && $stable(err_noconv) && $stable(err_narrow)));
endmodule

// File: tb/tap_eye_cal_tb.sv
module tap_eye_cal_tb;
  localparam int NT = 32, EW = 16, DW = 4, PS = 20, MS = 4;
  localparam int TT = 2 * DW + 4;

  typedef struct {
    int best; int span; bit noconv; bit narrow; int cycles; int loads; int rises;
  } exp_t;

  logic clk = 0, rst_n = 0, start = 0;
  logic chk_i_lock, chk_q_lock;
  logic [EW-1:0] chk_i_errs, chk_q_errs;
  logic [4:0] dly_tap, best_tap, win_span;
  logic dly_load, chk_en, chk_q, busy, done, err_noconv, err_narrow;

  tap_eye_cal #(.NUM_TAPS(NT), .ERR_W(EW), .DWELL(DW), .PAUSE(PS), .MIN_SPAN(MS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .chk_i_lock(chk_i_lock), .chk_i_errs(chk_i_errs),
    .chk_q_lock(chk_q_lock), .chk_q_errs(chk_q_errs),
    .dly_tap(dly_tap), .dly_load(dly_load), .chk_en(chk_en), .chk_q(chk_q),
    .busy(busy), .done(done), .best_tap(best_tap), .win_span(win_span),
    .err_noconv(err_noconv), .err_narrow(err_narrow));

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  int cyc = 0, cyc_start = 0, loads = 0, rises = 0, sweeps = 0, runs_seen = 0;
  logic [31:0] mi [2], mq [2];
  exp_t q[$];
  logic done_p = 0, en_p = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    int a;
    a = (sweeps >= 2) ? 1 : 0;
    chk_i_lock = 1'b1;
    chk_i_errs = mi[a][dly_tap] ? '0 : EW'(5);
    chk_q_lock = mq[a][dly_tap];
    chk_q_errs = '0;
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(logic [31:0] i0, q0, i1, q1);
    exp_t e; int c; bit have, ok, fin; int ws, we;
    logic [31:0] p;
    c = 0; have = 0; ok = 0; ws = 0; we = 0;
    e.loads = 0; e.rises = 0;
    for (int a = 0; a < 2; a++) begin
      int taps;
      p = (a == 0) ? (i0 & q0) : (i1 & q1);
      have = 0; taps = 0; fin = 0;
      for (int t = 0; t < NT && !fin; t++) begin
        taps++;
        if (p[t]) begin
          if (!have) begin have = 1; ws = t; end
          we = t;
        end else if (have) begin
          if (we - ws >= MS) fin = 1;
          else have = 0;
        end
      end
      c += taps * TT; e.loads += taps; e.rises += 2 * taps;
      ok = have && (we - ws >= MS);
      if (ok || a == 1) break;
      c += PS;
    end
    e.cycles = c + 1;
    if (ok) e.loads++;
    e.best = ok ? (ws + we) / 2 : 0;
    e.span = have ? we - ws : 0;
    e.noconv = !have;
    e.narrow = have && !ok;
    return e;
  endfunction

  always @(negedge clk) begin
    if (dly_load && busy && dly_tap == 0) sweeps++;
    if (dly_load) loads++;
    if (chk_en && !en_p) rises++;
    en_p = chk_en;
    if (done && !done_p && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(cyc - cyc_start == e.cycles, "R9", "done latency", cyc - cyc_start, e.cycles);
      check(best_tap == 5'(e.best), "R7", "best_tap", best_tap, e.best);
      check(win_span == 5'(e.span), "R4", "win_span", win_span, e.span);
      check(err_noconv == e.noconv, "R8", "err_noconv", err_noconv, e.noconv);
      check(err_narrow == e.narrow, "R8", "err_narrow", err_narrow, e.narrow);
      check(loads == e.loads, "R1", "load pulses", loads, e.loads);
      check(rises == e.rises, "R2", "checker restarts", rises, e.rises);
      if (!e.noconv && !e.narrow)
        check(dly_tap == 5'(e.best), "R7", "final dly_tap", dly_tap, e.best);
      check(!chk_en, "R2", "checker off at done", chk_en, 0);
      runs_seen++;
    end
    done_p = done;
  end

  task automatic run_cal(logic [31:0] i0, q0, i1, q1, bit poke);
    int target;
    mi[0] = i0; mq[0] = q0; mi[1] = i1; mq[1] = q1;
    q.push_back(model(i0, q0, i1, q1));
    target = runs_seen + 1;
    @(negedge clk);
    loads = 0; rises = 0; sweeps = 0; start = 1;
    @(negedge clk);
    start = 0; cyc_start = cyc;
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    while (runs_seen < target) @(negedge clk);
    begin
      logic [4:0] bt, sp; logic nc, nr;
      bt = best_tap; sp = win_span; nc = err_noconv; nr = err_narrow;
      repeat (10) @(negedge clk);
      check(done && best_tap == bt && win_span == sp && err_noconv == nc && err_narrow == nr,
            "R9", "results held while idle", {27'(0), best_tap}, {27'(0), bt});
    end
  endtask

  initial begin
    mi[0] = '1; mq[0] = '1; mi[1] = '1; mq[1] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !dly_load && !chk_en, "R10", "reset state",
          {busy, done, dly_load, chk_en}, 0);
    run_cal(32'h0000_1FE0, '1, '1, '1, 0);              // R3 I errors, R4 stop
    run_cal('1, 32'h001F_FC1C, '1, '1, 0);              // R4 discard narrow
    run_cal(32'hFE00_0000, '1, '1, '1, 0);              // R5 window at end
    run_cal('0, '1, 32'h0000_03FF, '1, 0);              // R6 retry
    run_cal('0, '0, '0, '0, 0);                         // R8 noconv
    run_cal(32'hF000_0000, '1, 32'hF000_0000, '1, 0);   // R8 narrow
    run_cal('1, 32'hFFFF_FEFF, '1, '1, 0);              // R3 Q unlocked penalty
    run_cal(32'h0000_1FE0, '1, '1, '1, 1);              // R9 start ignored while busy
    check(q.size() == 0, "R9", "all results seen", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule